// File: doc/BRIEF.md
# Pipelined Rational-Fraction Arithmetic Unit

This unit adds or multiplies two numbers that are each held as a fraction: a signed W-bit numerator over a signed W-bit denominator. It is meant for recursive filter datapaths that need more precision than plain fixed point gives, without the cost of floating point. A request carries two operands and a one-bit operation select. The unit takes at most one request per cycle through a valid/ready handshake on its input. Each result leaves through a valid/ready handshake on its output, after a fixed number of pipeline stages.

Inside, the unit forms the exact cross-products at double width. It then makes the denominator positive. Finally it shifts numerator and denominator right by the same amount, so that both fit back into W bits. A common shift only drops low-order detail, so the value of the fraction is kept as closely as the shift allows.

Back-pressure rules: the whole pipeline advances together. `in_ready` is high whenever the output stage is empty or the consumer has `out_ready` high. `in_ready` never depends on `in_valid`. While `out_valid` is high and `out_ready` is low, the presented result holds steady and no new request is accepted. An operand with a zero denominator does not stall the unit. Its result is marked bad, and a sticky error pin is raised.

Top module: `ratio_alu`

## Requirements
- R1: With `in_op` = 1 (multiply), the unnormalised result is N = xn·yn and D = xd·yd, computed exactly.
- R2: With `in_op` = 0 (add), the unnormalised result is N = xn·yd + yn·xd and D = xd·yd, computed exactly.
- R3: If D is negative, N and D are both negated. Every result with `out_bad` = 0 has `out_den` > 0.
- R4: Let M = |N| OR D, taken bitwise. If M < 2^(W-1), the shift s is 0. Otherwise s = (index of the highest set bit of M) − (W−2). The output is `out_num` = N arithmetically shifted right by s, and `out_den` = D shifted right by s.
- R5: A request accepted on clock edge k is presented with `out_valid` high right after edge k+3, when `out_ready` is held high. A new request can be accepted on every edge.
- R6: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, `out_num`, `out_den` and `out_bad` do not change.
- R7: A request accepted with `in_x_den` = 0 or `in_y_den` = 0 yields `out_bad` = 1. From the next cycle on, `err_zero_den` stays 1 until reset.
- R8: If the shifted denominator becomes 0 while both input denominators are nonzero, `out_bad` = 1 and `err_zero_den` is not affected.
- R9: During and right after reset, `out_valid` = 0, `err_zero_den` = 0 and `in_ready` = 1.
- R10: Results leave in the order their requests were accepted, one result per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit accepts the request on this edge |
| in_op | input | 1 | 0 = add, 1 = multiply |
| in_x_num | input | W | First operand numerator, signed |
| in_x_den | input | W | First operand denominator, signed |
| in_y_num | input | W | Second operand numerator, signed |
| in_y_den | input | W | Second operand denominator, signed |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_num | output | W | Result numerator, signed |
| out_den | output | W | Result denominator, positive when the result is good |
| out_bad | output | 1 | Result is invalid (zero or underflowed denominator) |
| err_zero_den | output | 1 | Sticky flag: a zero input denominator was seen |

## Verification
The bench targets several corner cases, each tied to a specific failure.

- **Negative operand denominator.** A design that skips the sign fix would emit a negative `out_den`.
- **Sum whose magnitude needs several bits of shift.** A wrong leading-one search would give a shift off by one, which halves or doubles both fields.
- **Negative numerator shifted right.** This exposes a logical shift used in place of an arithmetic one, which would turn the sign positive.
- **Overflow of a huge numerator over a tiny denominator.** This drives the denominator to zero. The bench checks that the result is flagged bad but leaves the sticky zero-denominator pin low.

Stalls with `out_ready` low probe whether a held result drifts or whether requests are lost or reordered across the stall.

// File: rtl/ratio_pkg.sv
package ratio_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_MUL = 1'b1
  } ratio_op_e;
endpackage

// File: rtl/ratio_mul_stage.sv
// Stage 1: exact cross-products at double width.
module ratio_mul_stage
  import ratio_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                   clk,
  input  logic                   en,
  input  ratio_op_e              op_i,
  input  logic signed [W-1:0]    xn,
  input  logic signed [W-1:0]    xd,
  input  logic signed [W-1:0]    yn,
  input  logic signed [W-1:0]    yd,
  output ratio_op_e              op_q,
  output logic signed [2*W-1:0]  p_main_q,
  output logic signed [2*W-1:0]  p_cross_q,
  output logic signed [2*W-1:0]  p_den_q,
  output logic                   bad_q
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] xn_e, xd_e, yn_e, yd_e, sel_e;

  assign xn_e  = PW'(xn);
  assign xd_e  = PW'(xd);
  assign yn_e  = PW'(yn);
  assign yd_e  = PW'(yd);
  assign sel_e = (op_i == OP_MUL) ? yn_e : yd_e;

  always_ff @(posedge clk) begin
    if (en) begin
      op_q      <= op_i;
      p_main_q  <= xn_e * sel_e;
      p_cross_q <= yn_e * xd_e;
      p_den_q   <= xd_e * yd_e;
      bad_q     <= (xd == '0) || (yd == '0);
    end
  end
endmodule

// File: rtl/ratio_combine.sv
// Stage 2: form numerator, keep the denominator positive.
module ratio_combine
  import ratio_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                     clk,
  input  logic                     en,
  input  ratio_op_e                op_i,
  input  logic signed [2*W-1:0]    p_main,
  input  logic signed [2*W-1:0]    p_cross,
  input  logic signed [2*W-1:0]    p_den,
  input  logic                     bad_i,
  output logic signed [2*W:0]      num_q,
  output logic signed [2*W:0]      den_q,
  output logic                     bad_q
);
  localparam int SW = 2 * W + 1;

  logic signed [SW-1:0] main_e, cross_e, den_e, raw_num;

  assign main_e  = SW'(p_main);
  assign cross_e = SW'(p_cross);
  assign den_e   = SW'(p_den);
  assign raw_num = (op_i == OP_ADD) ? (main_e + cross_e) : main_e;

  always_ff @(posedge clk) begin
    if (en) begin
      if (den_e < 0) begin
        num_q <= -raw_num;
        den_q <= -den_e;
      end else begin
        num_q <= raw_num;
        den_q <= den_e;
      end
      bad_q <= bad_i;
    end
  end
endmodule

// File: rtl/ratio_norm_find.sv
// Stage 3: choose the common right shift from the leading one.
module ratio_norm_find #(
  parameter int W = 16
) (
  input  logic                            clk,
  input  logic                            en,
  input  logic signed [2*W:0]             num_i,
  input  logic signed [2*W:0]             den_i,
  input  logic                            bad_i,
  output logic signed [2*W:0]             num_q,
  output logic signed [2*W:0]             den_q,
  output logic [$clog2(2*W+1)-1:0]        sh_q,
  output logic                            bad_q
);
  localparam int SW  = 2 * W + 1;
  localparam int SHW = $clog2(SW);
  localparam logic [SHW-1:0] KEEP = SHW'(W - 2);

  logic [SW-1:0]  mag;
  logic [SHW-1:0] lead;
  logic [SHW-1:0] sh;

  assign mag = ((num_i < 0) ? SW'(-num_i) : SW'(num_i)) | den_i;

  always_comb begin
    lead = '0;
    for (int i = 0; i < SW; i++) begin
      if (mag[i]) lead = SHW'(i);
    end
    sh = (lead > KEEP) ? (lead - KEEP) : '0;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      num_q <= num_i;
      den_q <= den_i;
      sh_q  <= sh;
      bad_q <= bad_i;
    end
  end
endmodule

// File: rtl/ratio_norm_apply.sv
// Stage 4: apply the shift and narrow back to W bits.
module ratio_norm_apply #(
  parameter int W = 16
) (
  input  logic                            clk,
  input  logic                            en,
  input  logic signed [2*W:0]             num_i,
  input  logic signed [2*W:0]             den_i,
  input  logic [$clog2(2*W+1)-1:0]        sh_i,
  input  logic                            bad_i,
  output logic signed [W-1:0]             num_q,
  output logic signed [W-1:0]             den_q,
  output logic                            bad_q
);
  localparam int SW = 2 * W + 1;

  logic signed [SW-1:0] num_s, den_s;

  assign num_s = num_i >>> sh_i;
  assign den_s = den_i >>> sh_i;

  always_ff @(posedge clk) begin
    if (en) begin
      num_q <= num_s[W-1:0];
      den_q <= den_s[W-1:0];
      bad_q <= bad_i || (den_s == '0);
    end
  end
endmodule

// File: rtl/ratio_alu.sv
module ratio_alu
  import ratio_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_op,
  input  logic signed [W-1:0]  in_x_num,
  input  logic signed [W-1:0]  in_x_den,
  input  logic signed [W-1:0]  in_y_num,
  input  logic signed [W-1:0]  in_y_den,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [W-1:0]  out_num,
  output logic signed [W-1:0]  out_den,
  output logic                 out_bad,
  output logic                 err_zero_den
);
  localparam int PW     = 2 * W;
  localparam int SW     = 2 * W + 1;
  localparam int SHW    = $clog2(SW);
  localparam int STAGES = 4;

  logic              adv;
  logic [STAGES-1:0] vld;

  assign adv       = !vld[STAGES-1] || out_ready;
  assign in_ready  = adv;
  assign out_valid = vld[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else if (adv) vld <= {vld[STAGES-2:0], in_valid};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_zero_den <= 1'b0;
    else if (in_valid && adv && (in_x_den == '0 || in_y_den == '0))
      err_zero_den <= 1'b1;
  end

  ratio_op_e            s1_op;
  logic signed [PW-1:0] s1_main, s1_cross, s1_den;
  logic                 s1_bad;

  ratio_mul_stage #(.W(W)) u_mul (
    .clk(clk), .en(adv), .op_i(ratio_op_e'(in_op)),
    .xn(in_x_num), .xd(in_x_den), .yn(in_y_num), .yd(in_y_den),
    .op_q(s1_op), .p_main_q(s1_main), .p_cross_q(s1_cross),
    .p_den_q(s1_den), .bad_q(s1_bad)
  );

  logic signed [SW-1:0] s2_num, s2_den;
  logic                 s2_bad;

  ratio_combine #(.W(W)) u_comb (
    .clk(clk), .en(adv), .op_i(s1_op),
    .p_main(s1_main), .p_cross(s1_cross), .p_den(s1_den), .bad_i(s1_bad),
    .num_q(s2_num), .den_q(s2_den), .bad_q(s2_bad)
  );

  logic signed [SW-1:0] s3_num, s3_den;
  logic [SHW-1:0]       s3_sh;
  logic                 s3_bad;

  ratio_norm_find #(.W(W)) u_find (
    .clk(clk), .en(adv), .num_i(s2_num), .den_i(s2_den), .bad_i(s2_bad),
    .num_q(s3_num), .den_q(s3_den), .sh_q(s3_sh), .bad_q(s3_bad)
  );

  ratio_norm_apply #(.W(W)) u_apply (
    .clk(clk), .en(adv), .num_i(s3_num), .den_i(s3_den), .sh_i(s3_sh),
    .bad_i(s3_bad), .num_q(out_num), .den_q(out_den), .bad_q(out_bad)
  );
endmodule

// File: rtl/ratio_alu_chk.sv
module ratio_alu_chk #(
  parameter int W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic signed [W-1:0]  in_x_den,
  input logic signed [W-1:0]  in_y_den,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [W-1:0]  out_num,
  input logic signed [W-1:0]  out_den,
  input logic                 out_bad,
  input logic                 err_zero_den
);
  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_num) && $stable(out_den) && $stable(out_bad)));

  // R6
  ready_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);

  // R3
  den_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_bad) |-> (out_den > 0));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_zero_den |=> err_zero_den);

  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_x_den == '0 || in_y_den == '0)) |=> err_zero_den);

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !err_zero_den));
endmodule

bind ratio_alu ratio_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_x_den(in_x_den), .in_y_den(in_y_den), .out_valid(out_valid),
  .out_ready(out_ready), .out_num(out_num), .out_den(out_den),
  .out_bad(out_bad), .err_zero_den(err_zero_den)
);

// File: tb/tb_ratio_alu.sv
module tb_ratio_alu;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_op = 1'b0, out_ready = 1'b0;
  logic signed [W-1:0] in_x_num = '0, in_x_den = '0, in_y_num = '0, in_y_den = '0;
  logic in_ready, out_valid, out_bad, err_zero_den;
  logic signed [W-1:0] out_num, out_den;

  always #4 clk = ~clk;

  ratio_alu #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_x_num(in_x_num), .in_x_den(in_x_den),
    .in_y_num(in_y_num), .in_y_den(in_y_den), .out_valid(out_valid),
    .out_ready(out_ready), .out_num(out_num), .out_den(out_den),
    .out_bad(out_bad), .err_zero_den(err_zero_den)
  );

  typedef struct {
    logic signed [W-1:0] n;
    logic signed [W-1:0] d;
    bit                  bad;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected value from R1..R4, R7, R8
  function automatic exp_t model(input bit op, input longint xn, input longint xd,
                                 input longint yn, input longint yd);
    longint nn, dd, mm;
    int s;
    exp_t r;
    nn = op ? xn * yn : xn * yd + yn * xd;
    dd = xd * yd;
    if (dd < 0) begin nn = -nn; dd = -dd; end
    mm = ((nn < 0) ? -nn : nn) | dd;
    s = 0;
    for (int i = 0; i < 48; i++) if (mm[i]) s = i;
    s = (s > W - 2) ? s - (W - 2) : 0;
    r.n = W'(nn >>> s);
    r.d = W'(dd >>> s);
    r.bad = (xd == 0) || (yd == 0) || ((dd >>> s) == 0);
    return r;
  endfunction

  task automatic step(input bit iv, input bit op, input int xn, input int xd,
                      input int yn, input int yd, input bit ordy);
    exp_t e;
    @(negedge clk);
    out_ready = ordy;
    in_valid  = iv;
    in_op     = op;
    in_x_num  = W'(xn); in_x_den = W'(xd);
    in_y_num  = W'(yn); in_y_den = W'(yd);
    #1;
    if (out_valid && out_ready) begin
      if (q.size() == 0) chk(0, "R10 unexpected result", 1, 0);
      else begin
        e = q.pop_front();
        if (e.bad) chk(out_bad == 1'b1, "R7/R8 bad flag", out_bad, 1);
        else begin
          chk(out_bad == 1'b0, "R1/R2 bad flag", out_bad, 0);
          chk(out_num == e.n, "R1/R2/R4 numerator", out_num, e.n);
          chk(out_den == e.d, "R3/R4 denominator", out_den, e.d);
        end
      end
    end
    if (in_valid && in_ready)
      q.push_back(model(op, longint'(in_x_num), longint'(in_x_den),
                        longint'(in_y_num), longint'(in_y_den)));
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 0, 1, 1);
    chk(q.size() == 0, "R10 all results returned", q.size(), 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic signed [W-1:0] held_n, held_d;
    void'($urandom(32'd20240611));
    #10;
    // R9 reset state
    chk(out_valid == 1'b0, "R9 out_valid in reset", out_valid, 0);
    chk(err_zero_den == 1'b0, "R9 err in reset", err_zero_den, 0);
    chk(in_ready == 1'b1, "R9 in_ready in reset", in_ready, 1);
    @(negedge clk); rst_n = 1'b1;

    // R5 latency: accept on edge k, visible after edge k+3
    step(1, 1, 1, 2, 3, 4, 1);
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 0, 1, 0, 1, 1);
      chk(out_valid == 1'b0, "R5 not yet valid", out_valid, 0);
    end
    step(0, 0, 0, 1, 0, 1, 1);
    chk(out_valid == 1'b1, "R5 valid after four stages", out_valid, 1);
    drain();

    // R2 add, R3 negative denominator, R4 multi-bit shifts, back-to-back (R5)
    step(1, 0, 1, 2, 1, 3, 1);
    step(1, 1, 1, -2, 3, 4, 1);
    step(1, 0, 30000, 7, 30001, 9, 1);
    step(1, 1, -30000, 20000, 30000, 20000, 1);
    step(1, 0, -32768, -1, 32767, 3, 1);
    drain();

    // R8 denominator underflow, no sticky error
    step(1, 1, -30000, 1, 30000, 1, 1);
    drain();
    chk(err_zero_den == 1'b0, "R8 err untouched", err_zero_den, 0);

    // R6 back-pressure: fill, hold, check stability and ready
    for (int i = 0; i < 6; i++) step(1, i[0], 100 + i, 3, 7, 5 + i, 0);
    chk(out_valid == 1'b1, "R6 stalled output present", out_valid, 1);
    chk(in_ready == 1'b0, "R6 in_ready low in stall", in_ready, 0);
    held_n = out_num; held_d = out_den;
    step(1, 0, 9, 9, 9, 9, 0);
    chk(out_num == held_n, "R6 numerator held", out_num, held_n);
    chk(out_den == held_d, "R6 denominator held", out_den, held_d);
    drain();

    // R7 zero denominator, sticky error
    step(1, 0, 1, 0, 1, 1, 1);
    step(0, 0, 0, 1, 0, 1, 1);
    chk(err_zero_den == 1'b1, "R7 err raised", err_zero_den, 1);
    drain();
    chk(err_zero_den == 1'b1, "R7 err sticky", err_zero_den, 1);

    // Random mix, R1 R2 R10 under random back-pressure
    for (int i = 0; i < 4000; i++) begin
      int xn, xd, yn, yd;
      bit rdy;
      xn = int'($signed(16'($urandom())));
      yn = int'($signed(16'($urandom())));
      if ($urandom_range(0, 1) == 0) begin
        xd = int'($signed(16'($urandom())));
        yd = int'($signed(16'($urandom())));
      end else begin
        xd = $urandom_range(1, 50) * (($urandom_range(0, 1) == 0) ? 1 : -1);
        yd = $urandom_range(1, 50);
        xn = xn % 200;
      end
      if (xd == 0) xd = 1;
      if (yd == 0) yd = 1;
      rdy = ($urandom_range(0, 3) != 0);
      step($urandom_range(0, 4) != 0, 1'($urandom()), xn, xd, yn, yd, rdy);
      if (rdy) chk(in_ready == 1'b1, "R6 ready follows out_ready", in_ready, 1);
    end
    drain();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule